// File: doc/BRIEF.md
# Eight-Bit Function-Coded Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit working on two 8-bit operands, B and C. A 3-bit function code chooses one of seven operations: addition, increment, AND, OR, XOR, NOT, and a circular left shift. The code is expanded into one-hot select lines. Each select line gates a single result path onto a shared 8-bit result bus, so no other path can reach the bus.

An output enable qualifies the whole unit. When the enable is low, no path is selected and the bus reads 0x00. Three condition outputs go with the result. Carry comes from the ripple adder. Zero and sign are both taken from the bus itself, so they always describe the value that is actually driven.

Top module: `alu8_fc`

## Requirements
- R1: With the enable high and code 000, the result is (B + C) mod 256 and carry equals bit 8 of the 9-bit sum. The carry-in of the adder is 0.
- R2: With the enable high and code 001, the result is (B + 1) mod 256. Carry is 1 only when B is 0xFF.
- R3: With the enable high, code 010 gives B AND C, code 011 gives B OR C, and code 100 gives B XOR C, bit by bit.
- R4: With the enable high and code 101, the result is the bitwise inverse of B, and C has no effect.
- R5: With the enable high and code 110, result bit i equals B bit i-1 for i from 1 to 7, and result bit 0 equals B bit 7. C has no effect.
- R6: Code 111 selects no path. The result is 0x00 and carry is 0.
- R7: With the enable low, the result is 0x00 for every code and operand value.
- R8: Carry is 0 unless the enable is high and the code is 000 or 001.
- R9: Zero is 1 exactly when all 8 bits of the result are 0.
- R10: Sign equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oe_i | input | 1 | Output enable; when low, no path drives the bus |
| fn_i | input | 3 | Function code (000 add, 001 inc, 010 and, 011 or, 100 xor, 101 not, 110 rotate left, 111 none) |
| b_i | input | 8 | Operand B |
| c_i | input | 8 | Operand C |
| res_o | output | 8 | Result bus |
| carry_o | output | 1 | Adder carry-out for add and increment |
| zero_o | output | 1 | Result bus is all zero |
| sign_o | output | 1 | Bit 7 of the result bus |

## Verification
Carry and zero can both be asserted for the same input. This happens when an addition overflows to exactly 0x00, for example 0x80 + 0x80, or when 0xFF is incremented. The bench reaches these cases by sweeping every B and C pair under the add code and B through 0xFF under increment. For each vector, it compares the full flag set against an arithmetic model. The model works out the 9-bit sum as an integer, then derives zero and sign from the expected 8-bit result.

// File: rtl/alu8_fc.sv
module alu8_fc #(
  parameter int W  = 8,
  parameter int FW = 3
) (
  input  logic          oe_i,
  input  logic [FW-1:0] fn_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          sign_o
);
  localparam int NF    = 1 << FW;
  localparam int F_ADD = 0;
  localparam int F_INC = 1;
  localparam int F_AND = 2;
  localparam int F_OR  = 3;
  localparam int F_XOR = 4;
  localparam int F_NOT = 5;
  localparam int F_SHL = 6;

  logic [NF-1:0] sel;
  logic [W-1:0]  addend, sum, and_v, or_v, xor_v, not_v, shl_v;
  logic [W:0]    cy;
  logic [W:0]    zc;
  logic          arith;

  for (genvar k = 0; k < NF; k++) begin : g_dec
    assign sel[k] = oe_i & (fn_i == FW'(k));
  end

  assign arith  = sel[F_ADD] | sel[F_INC];
  assign addend = sel[F_INC] ? W'(1) : c_i;
  assign cy[0]  = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    assign sum[i]   = b_i[i] ^ addend[i] ^ cy[i];
    assign cy[i+1]  = (b_i[i] & addend[i]) | (cy[i] & (b_i[i] ^ addend[i]));
    assign and_v[i] = b_i[i] & c_i[i];
    assign or_v[i]  = b_i[i] | c_i[i];
    assign xor_v[i] = b_i[i] ^ c_i[i];
    assign not_v[i] = ~b_i[i];
    assign shl_v[i] = b_i[(i + W - 1) % W];
  end

  assign res_o = ({W{arith}}      & sum)
               | ({W{sel[F_AND]}} & and_v)
               | ({W{sel[F_OR]}}  & or_v)
               | ({W{sel[F_XOR]}} & xor_v)
               | ({W{sel[F_NOT]}} & not_v)
               | ({W{sel[F_SHL]}} & shl_v);

  assign carry_o = arith & cy[W];

  assign zc[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_zero
    assign zc[i+1] = zc[i] & ~res_o[i];
  end
  assign zero_o = zc[W];
  assign sign_o = res_o[W-1];

  always_comb begin
    if (!oe_i)
      a_r7_disabled_quiet: assert (res_o == '0 && !carry_o && zero_o);
    if (fn_i == FW'(NF - 1))
      a_r6_unused_code: assert (res_o == '0 && !carry_o);
    if (fn_i != FW'(F_ADD) && fn_i != FW'(F_INC))
      a_r8_carry_only_arith: assert (!carry_o);
    if (oe_i && fn_i == FW'(F_ADD))
      a_r1_add_sum: assert ({carry_o, res_o} == ({1'b0, b_i} + {1'b0, c_i}));
    if (oe_i && fn_i == FW'(F_SHL))
      a_r5_wrap_bit: assert (res_o[0] == b_i[W-1]);
    a_r9_zero_match: assert (zero_o == (res_o == '0));
  end
endmodule

// File: tb/tb_alu8_fc.sv
module tb_alu8_fc;
  logic       clk = 1'b0;
  logic       oe;
  logic [2:0] fn;
  logic [7:0] b, c;
  logic [7:0] res;
  logic       carry, zero, sign;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  alu8_fc dut (
    .oe_i(oe), .fn_i(fn), .b_i(b), .c_i(c),
    .res_o(res), .carry_o(carry), .zero_o(zero), .sign_o(sign)
  );

  function automatic string tag_of(input logic o, input int f);
    if (!o) return "R7";
    case (f)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic o, input int f, input int bv, input int cv);
    int s, er, ec, ez, es;
    oe = o; fn = 3'(f); b = 8'(bv); c = 8'(cv);
    case (f)
      0: s = bv + cv;
      1: s = bv + 1;
      2: s = bv & cv;
      3: s = bv | cv;
      4: s = bv ^ cv;
      5: s = (~bv) & 255;
      6: s = ((bv * 2) + (bv / 128)) & 255;
      default: s = 0;
    endcase
    if (!o) s = 0;
    er = s & 255;
    ec = (o && f <= 1) ? (s / 256) : 0;
    ez = (er == 0) ? 1 : 0;
    es = er / 128;
    #1;
    n_vec++;
    if (int'(res) != er) begin
      n_bad++;
      $display("FAIL %s res oe=%0d fn=%0d b=%02h c=%02h actual=%02h expected=%02h",
               tag_of(o, f), o, f, bv, cv, res, er);
    end
    if (int'(carry) != ec) begin
      n_bad++;
      $display("FAIL R8 carry oe=%0d fn=%0d b=%02h c=%02h actual=%0d expected=%0d",
               o, f, bv, cv, carry, ec);
    end
    if (int'(zero) != ez) begin
      n_bad++;
      $display("FAIL R9 zero oe=%0d fn=%0d b=%02h c=%02h actual=%0d expected=%0d",
               o, f, bv, cv, zero, ez);
    end
    if (int'(sign) != es) begin
      n_bad++;
      $display("FAIL R10 sign oe=%0d fn=%0d b=%02h c=%02h actual=%0d expected=%0d",
               o, f, bv, cv, sign, es);
    end
  endtask

  initial begin
    // quiet state with enable low: R7
    apply(1'b0, 0, 8'hFF, 8'hFF);
    // R1 and R3: full B x C sweep for two-operand codes
    for (int f = 0; f < 5; f++) begin
      if (f == 1) continue;
      for (int bv = 0; bv < 256; bv++)
        for (int cv = 0; cv < 256; cv++)
          apply(1'b1, f, bv, cv);
    end
    // R2, R4, R5, R6: C must not matter
    for (int f = 1; f < 8; f++) begin
      if (f >= 2 && f <= 4) continue;
      for (int bv = 0; bv < 256; bv++)
        for (int cv = 0; cv < 256; cv += 17)
          apply(1'b1, f, bv, cv);
    end
    // R7 and R8: enable low for every code
    for (int f = 0; f < 8; f++)
      for (int bv = 0; bv < 256; bv++)
        for (int cv = 0; cv < 256; cv += 51)
          apply(1'b0, f, bv, cv);
    // carry and zero together: R1, R2
    apply(1'b1, 0, 8'h80, 8'h80);
    apply(1'b1, 1, 8'hFF, 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule